// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block tracks where a DMA network controller stands in its two descriptor rings, one for transmit and one for receive. For each ring it keeps the base address, a size field, the address of the descriptor being worked on (the current pointer) and the address of the one to fetch after it (the next pointer). All of these are full byte addresses, not indexes. A simple register port lets software program and read them. The block does not fetch descriptors and raises no interrupts.

A transmit or receive engine pulses *claim* to ask which descriptor to use. The stored next pointer is range-checked against the ring in the same cycle. If it lies outside the ring it is replaced by the ring base, and the chosen address is returned at once and latched as the current pointer. When the engine has finished with that descriptor it pulses *done*, and the next pointer moves one descriptor on, wrapping to the base at the ring end. Two events put both pointers of every ring back on their base: a device reset, or a write of the soft-reset bit.

Top module: `desc_ring_ptr_mgr`

## Requirements
- R1: While `rst_n` is low and after it is released, every register and all four ring pointers read zero, and both conflict flags are 0.
- R2: Register offsets:
  - transmit base: 0x100
  - receive base: 0x104
  - sizes: 0x10C, with the transmit field at bits [SZ_W-1:0] and the receive field at bits [16+SZ_W-1:16]
  - transmit current pointer: 0x11C
  - receive current pointer: 0x120
  - transmit next pointer: 0x134
  - receive next pointer: 0x138
  - control: 0x144, with bit 0 as soft reset; it reads as zero

  Reads are combinational from `reg_addr`.
- R3: The ring length is the size field plus one, and each ring has its own size field. A descriptor is 8 bytes. The ring end is base plus length times 8, computed one bit wider than the address.
- R4: In a cycle with claim high, the descriptor address output equals the next pointer when next ≥ base and next + 8 ≤ ring end. Otherwise it equals the base.
- R5: From the cycle after a claim, the current pointer holds the address that the claim returned. A claim leaves the next pointer unchanged.
- R6: A done pulse sets the next pointer to current + 8. If that value is at or beyond the ring end, the next pointer is set to the base instead.
- R7: A register write to the control register with bit 0 set loads the current and next pointers of both rings with their own base. A soft reset outranks every other update in that cycle.
- R8: Software writes to the current and next pointer registers are stored as written. An out-of-ring next pointer is corrected only by the range check at the next claim.
- R9: If claim and done are high together for one ring, the claim is carried out and the done is dropped, so the next pointer is unchanged. That ring's conflict flag is 1 for exactly the following cycle.
- R10: Claims and done pulses on one ring leave the other ring's pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_claim | input | 1 | Transmit engine requests a descriptor address |
| tx_done | input | 1 | Transmit engine finished the current descriptor |
| tx_desc_addr | output | AW | Validated transmit descriptor address |
| tx_conflict | output | 1 | Transmit claim and done collided in the previous cycle |
| rx_claim | input | 1 | Receive engine requests a descriptor address |
| rx_done | input | 1 | Receive engine finished the current descriptor |
| rx_desc_addr | output | AW | Validated receive descriptor address |
| rx_conflict | output | 1 | Receive claim and done collided in the previous cycle |

## Verification
The bench builds the block with a 32-bit address and a 4-bit size field, so a ring holds at most 16 descriptors. With the transmit ring at four entries and the receive ring at two, both wrap points are reached within a few done pulses. Each side of the range check is placed exactly: a pointer below the base, a pointer whose descriptor ends 4 bytes past the ring end, and the last legal slot. Different lengths on the two rings also show that the size fields are really separate.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

   localparam int DESC_BYTES = 8;
   localparam int NUM_DIR    = 2;
   localparam int OFS_W      = 12;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } ring_dir_e;

   localparam logic [OFS_W-1:0] OFS_TX_BASE = 12'h100;
   localparam logic [OFS_W-1:0] OFS_RX_BASE = 12'h104;
   localparam logic [OFS_W-1:0] OFS_SIZES   = 12'h10C;
   localparam logic [OFS_W-1:0] OFS_TX_CUR  = 12'h11C;
   localparam logic [OFS_W-1:0] OFS_RX_CUR  = 12'h120;
   localparam logic [OFS_W-1:0] OFS_TX_NEXT = 12'h134;
   localparam logic [OFS_W-1:0] OFS_RX_NEXT = 12'h138;
   localparam logic [OFS_W-1:0] OFS_CTRL    = 12'h144;

   localparam int SIZE_RX_LSB = 16;

   function automatic logic [OFS_W-1:0] cur_ofs(input ring_dir_e d);
      return (d == DIR_RX) ? OFS_RX_CUR : OFS_TX_CUR;
   endfunction

   function automatic logic [OFS_W-1:0] next_ofs(input ring_dir_e d);
      return (d == DIR_RX) ? OFS_RX_NEXT : OFS_TX_NEXT;
   endfunction

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
   import ring_ptr_pkg::*;
#(
   parameter int AW   = 32,
   parameter int SZ_W = 10,
   parameter int RA_W = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [RA_W-1:0]                 wr_addr,
   input  logic [31:0]                     wr_data,
   output logic [NUM_DIR-1:0][AW-1:0]      base_q,
   output logic [NUM_DIR-1:0][SZ_W-1:0]    size_q,
   output logic                            soft_rst
);

   localparam logic [RA_W-1:0] A_TXB  = RA_W'(OFS_TX_BASE);
   localparam logic [RA_W-1:0] A_RXB  = RA_W'(OFS_RX_BASE);
   localparam logic [RA_W-1:0] A_SZ   = RA_W'(OFS_SIZES);
   localparam logic [RA_W-1:0] A_CTRL = RA_W'(OFS_CTRL);

   assign soft_rst = wr_en && (wr_addr == A_CTRL) && wr_data[0];

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      localparam logic [RA_W-1:0] A_BASE = (d == 1) ? A_RXB : A_TXB;
      localparam int SZ_LSB = (d == 1) ? SIZE_RX_LSB : 0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[d] <= '0;
            size_q[d] <= '0;
         end else if (wr_en) begin
            if (wr_addr == A_BASE) base_q[d] <= wr_data[AW-1:0];
            if (wr_addr == A_SZ)   size_q[d] <= wr_data[SZ_LSB +: SZ_W];
         end
      end
   end

endmodule

// File: rtl/ring_dir_ptr.sv
module ring_dir_ptr
   import ring_ptr_pkg::*;
#(
   parameter int AW   = 32,
   parameter int SZ_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   base,
   input  logic [SZ_W-1:0] size_fld,
   input  logic            soft_rst,
   input  logic            claim,
   input  logic            done,
   input  logic            sw_cur_we,
   input  logic            sw_next_we,
   input  logic [AW-1:0]   sw_data,
   output logic [AW-1:0]   cur_q,
   output logic [AW-1:0]   nxt_q,
   output logic [AW-1:0]   claim_addr,
   output logic            conflict_q
);

   localparam int EW = AW + 1;

   logic [SZ_W:0]   ring_len;
   logic [EW-1:0]   span_x, end_x, step_x;
   logic            nxt_fits;
   logic [AW-1:0]   nxt_adv;

   always_comb begin
      ring_len = {1'b0, size_fld} + (SZ_W+1)'(1);
      span_x   = EW'(ring_len) * EW'(DESC_BYTES);
      end_x    = {1'b0, base} + span_x;
      nxt_fits = (nxt_q >= base) &&
                 (({1'b0, nxt_q} + EW'(DESC_BYTES)) <= end_x);
      claim_addr = nxt_fits ? nxt_q : base;
      step_x   = {1'b0, cur_q} + EW'(DESC_BYTES);
      nxt_adv  = (step_x >= end_x) ? base : step_x[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q      <= '0;
         nxt_q      <= '0;
         conflict_q <= 1'b0;
      end else begin
         conflict_q <= claim && done;
         if (soft_rst) begin
            cur_q <= base;
            nxt_q <= base;
         end else begin
            if (claim)          cur_q <= claim_addr;
            else if (sw_cur_we) cur_q <= sw_data;
            if (done && !claim)           nxt_q <= nxt_adv;
            else if (sw_next_we && !done) nxt_q <= sw_data;
         end
      end
   end

   // R4: the returned address always lies wholly inside the ring
   a_r4_claim_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> (claim_addr >= base) &&
                (({1'b0, claim_addr} + EW'(DESC_BYTES)) <= end_x));

   // R5: the current pointer takes up the claimed address
   a_r5_cur_takes_claim: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && !soft_rst) |=> (cur_q == $past(claim_addr)));

   // R6: after done the next pointer is one step on or back at the base
   a_r6_done_step: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !claim && !soft_rst) |=>
         ((nxt_q == $past(base)) ||
          ({1'b0, nxt_q} == {1'b0, $past(cur_q)} + EW'(DESC_BYTES))));

   // R7: soft reset puts both pointers on the base
   a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cur_q == $past(base)) && (nxt_q == $past(base)));

   // R9: a collision drops the done and flags it
   a_r9_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && done) |=> conflict_q);
   a_r9_next_held: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && done && !soft_rst) |=> $stable(nxt_q));

endmodule

// File: rtl/desc_ring_ptr_mgr.sv
module desc_ring_ptr_mgr
   import ring_ptr_pkg::*;
#(
   parameter int AW   = 32,
   parameter int SZ_W = 10,
   parameter int RA_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            tx_claim,
   input  logic            tx_done,
   output logic [AW-1:0]   tx_desc_addr,
   output logic            tx_conflict,
   input  logic            rx_claim,
   input  logic            rx_done,
   output logic [AW-1:0]   rx_desc_addr,
   output logic            rx_conflict
);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("desc_ring_ptr_mgr: AW must lie in 8..32");
   end
   if (SZ_W < 1 || SZ_W > 16) begin : g_bad_sz
      $error("desc_ring_ptr_mgr: SZ_W must lie in 1..16");
   end
   if (RA_W < OFS_W) begin : g_bad_ra
      $error("desc_ring_ptr_mgr: RA_W too narrow for the register map");
   end

   logic [NUM_DIR-1:0][AW-1:0]   base_q;
   logic [NUM_DIR-1:0][SZ_W-1:0] size_q;
   logic                         soft_rst;
   logic [NUM_DIR-1:0]           claim_v, done_v, conf_v;
   logic [NUM_DIR-1:0][AW-1:0]   cur_v, nxt_v, addr_v;

   assign claim_v = {rx_claim, tx_claim};
   assign done_v  = {rx_done, tx_done};

   ring_cfg_regs #(.AW(AW), .SZ_W(SZ_W), .RA_W(RA_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .base_q   (base_q),
      .size_q   (size_q),
      .soft_rst (soft_rst)
   );

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_ring
      localparam ring_dir_e DIR = (d == 1) ? DIR_RX : DIR_TX;
      localparam logic [RA_W-1:0] A_CUR  = RA_W'(cur_ofs(DIR));
      localparam logic [RA_W-1:0] A_NEXT = RA_W'(next_ofs(DIR));

      ring_dir_ptr #(.AW(AW), .SZ_W(SZ_W)) u_ptr (
         .clk        (clk),
         .rst_n      (rst_n),
         .base       (base_q[d]),
         .size_fld   (size_q[d]),
         .soft_rst   (soft_rst),
         .claim      (claim_v[d]),
         .done       (done_v[d]),
         .sw_cur_we  (reg_wr && (reg_addr == A_CUR)),
         .sw_next_we (reg_wr && (reg_addr == A_NEXT)),
         .sw_data    (reg_wdata[AW-1:0]),
         .cur_q      (cur_v[d]),
         .nxt_q      (nxt_v[d]),
         .claim_addr (addr_v[d]),
         .conflict_q (conf_v[d])
      );
   end

   assign tx_desc_addr = addr_v[DIR_TX];
   assign rx_desc_addr = addr_v[DIR_RX];
   assign tx_conflict  = conf_v[DIR_TX];
   assign rx_conflict  = conf_v[DIR_RX];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_W'(OFS_TX_BASE): reg_rdata = 32'(base_q[DIR_TX]);
         RA_W'(OFS_RX_BASE): reg_rdata = 32'(base_q[DIR_RX]);
         RA_W'(OFS_SIZES): begin
            reg_rdata[SZ_W-1:0]                     = size_q[DIR_TX];
            reg_rdata[SIZE_RX_LSB +: SZ_W]          = size_q[DIR_RX];
         end
         RA_W'(OFS_TX_CUR):  reg_rdata = 32'(cur_v[DIR_TX]);
         RA_W'(OFS_RX_CUR):  reg_rdata = 32'(cur_v[DIR_RX]);
         RA_W'(OFS_TX_NEXT): reg_rdata = 32'(nxt_v[DIR_TX]);
         RA_W'(OFS_RX_NEXT): reg_rdata = 32'(nxt_v[DIR_RX]);
         default:            reg_rdata = '0;
      endcase
   end

   // R10: activity on one ring leaves the other ring's next pointer alone
   a_r10_rx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_claim && !rx_done && !soft_rst && !reg_wr) |=> $stable(nxt_v[DIR_RX]) && $stable(cur_v[DIR_RX]));

endmodule

// File: tb/desc_ring_ptr_mgr_tb.sv
module desc_ring_ptr_mgr_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int SZ_W = 4;
   localparam int RA_W = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [RA_W-1:0] reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            tx_claim = 1'b0, tx_done = 1'b0;
   logic            rx_claim = 1'b0, rx_done = 1'b0;
   logic [AW-1:0]   tx_desc_addr, rx_desc_addr;
   logic            tx_conflict, rx_conflict;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_ring_ptr_mgr #(.AW(AW), .SZ_W(SZ_W), .RA_W(RA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_claim(tx_claim), .tx_done(tx_done), .tx_desc_addr(tx_desc_addr),
      .tx_conflict(tx_conflict), .rx_claim(rx_claim), .rx_done(rx_done),
      .rx_desc_addr(rx_desc_addr), .rx_conflict(rx_conflict)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic claim(input bit rx, input logic [31:0] exp, input string req);
      @(negedge clk);
      if (rx) rx_claim = 1'b1; else tx_claim = 1'b1;
      #1;
      chk(req, rx ? rx_desc_addr : tx_desc_addr, exp);
      @(negedge clk);
      rx_claim = 1'b0; tx_claim = 1'b0;
      rd_chk("R5 current after claim", rx ? 12'h120 : 12'h11C, exp);
   endtask

   task automatic done(input bit rx);
      @(negedge clk);
      if (rx) rx_done = 1'b1; else tx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0; tx_done = 1'b0;
   endtask

   task automatic t_reset_state;
      rd_chk("R1 tx cur", 12'h11C, 0);
      rd_chk("R1 tx next", 12'h134, 0);
      rd_chk("R1 rx cur", 12'h120, 0);
      rd_chk("R1 rx next", 12'h138, 0);
      rd_chk("R1 base", 12'h100, 0);
      chk("R1 conflict", {30'b0, rx_conflict, tx_conflict}, 0);
   endtask

   task automatic t_program;
      wr(12'h100, 32'h1000);
      wr(12'h104, 32'h2000);
      wr(12'h10C, 32'h0001_0003);
      rd_chk("R2 size readback", 12'h10C, 32'h0001_0003);
      rd_chk("R2 ctrl reads zero", 12'h144, 0);
      wr(12'h144, 32'h1);
      rd_chk("R7 tx cur", 12'h11C, 32'h1000);
      rd_chk("R7 tx next", 12'h134, 32'h1000);
      rd_chk("R7 rx cur", 12'h120, 32'h2000);
      rd_chk("R7 rx next", 12'h138, 32'h2000);
   endtask

   task automatic t_tx_walk;
      for (int i = 0; i < 4; i++) begin
         claim(0, 32'h1000 + 32'(i * 8), "R4 tx walk");
         done(0);
      end
      rd_chk("R6 R3 tx wrap after 4", 12'h134, 32'h1000);
   endtask

   task automatic t_bounds;
      wr(12'h134, 32'h0FF8);
      rd_chk("R8 sw next stored", 12'h134, 32'h0FF8);
      claim(0, 32'h1000, "R4 below base");
      rd_chk("R5 claim keeps next", 12'h134, 32'h0FF8);
      done(0);
      rd_chk("R6 step", 12'h134, 32'h1008);
      wr(12'h134, 32'h101C);
      claim(0, 32'h1000, "R4 straddles end");
      wr(12'h134, 32'h1018);
      claim(0, 32'h1018, "R4 last slot");
      done(0);
      rd_chk("R6 wrap at end", 12'h134, 32'h1000);
      wr(12'h11C, 32'h1234);
      rd_chk("R8 sw cur stored", 12'h11C, 32'h1234);
   endtask

   task automatic t_rx_ring;
      claim(1, 32'h2000, "R4 rx first");
      done(1);
      rd_chk("R6 rx step", 12'h138, 32'h2008);
      claim(1, 32'h2008, "R4 rx second");
      done(1);
      rd_chk("R3 rx wraps after 2", 12'h138, 32'h2000);
      rd_chk("R10 tx next untouched", 12'h134, 32'h1000);
      rd_chk("R10 tx cur untouched", 12'h11C, 32'h1234);
   endtask

   task automatic t_conflict;
      @(negedge clk);
      tx_claim = 1'b1; tx_done = 1'b1;
      #1;
      chk("R9 claim served", tx_desc_addr, 32'h1000);
      @(negedge clk);
      tx_claim = 1'b0; tx_done = 1'b0;
      #1;
      chk("R9 flag set", {31'b0, tx_conflict}, 1);
      chk("R9 rx flag clear", {31'b0, rx_conflict}, 0);
      rd_chk("R9 next unchanged", 12'h134, 32'h1000);
      rd_chk("R9 cur claimed", 12'h11C, 32'h1000);
      @(negedge clk);
      #1;
      chk("R9 flag one cycle", {31'b0, tx_conflict}, 0);
   endtask

   task automatic t_soft_again;
      wr(12'h100, 32'h3000);
      wr(12'h144, 32'h0);
      rd_chk("R7 bit0 clear no reset", 12'h134, 32'h1000);
      wr(12'h144, 32'h1);
      rd_chk("R7 new tx base", 12'h11C, 32'h3000);
      rd_chk("R7 rx base kept", 12'h138, 32'h2000);
   endtask

   task automatic t_hard_reset;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rd_chk("R1 async base", 12'h100, 0);
      rd_chk("R1 async next", 12'h134, 0);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_program();
      t_tx_walk();
      t_bounds();
      t_rx_ring();
      t_conflict();
      t_soft_again();
      t_hard_reset();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule